// File: doc/BRIEF.md
# Automatic Entropy Request Sequencer

This block sits in front of the command port of a random-bit generator and decides which 32-bit command words are sent to it and when. Each word leaves through a registered valid/ready output. The generator answers each complete command with a one-cycle acknowledge, which carries an error flag. The sequencer has three ways of working. In software mode it forwards words that firmware writes. In boot mode it sends two preloaded words, an instantiate and then a generate, with no firmware involved. In automatic mode it replays stored command programs forever.

In automatic mode firmware first stores a generate program and a reseed program, and sets a limit on the number of generate requests allowed between reseeds. It then writes a single instantiate word. From the acknowledge of that word onwards the sequencer takes over. It sends the generate program after every acknowledge. A hardened down-counter decides when the reseed program goes out in place of a generate. The stored programs are read without being removed, so they can be replayed without limit. Overflowing a program store, a mismatch between the counter copies, or a corrupted state code stops the block for good, until the next reset.

Top module: `rng_cmd_sequencer`

## Requirements
- R1: After reset the state code reads 0x185, and cmd_valid, rdy, cmd_sts, sw_done and fatal_err are all 0. The boot instantiate word resets to 0x0000_0901 and the boot generate word resets to 0x00FF_F003.
- R2: Raising enable with boot_mode set sends the boot instantiate word on the second clock edge. The boot generate word goes out only after an acknowledge. After the acknowledge of the generate word nothing more is sent while boot_mode stays high. Clearing boot_mode then returns the block to idle, and with enable still high it moves on to software mode.
- R3: In software mode rdy is 1 only while no word is being held. A sw_cmd_we strobe while rdy is 1 puts the wdata word on cmd_word with cmd_valid high after one edge, and rdy then reads 0.
- R4: While cmd_valid is 1 and cmd_ready is 0, cmd_valid and cmd_word stay unchanged.
- R5: Every acknowledge copies cmd_ack_err into cmd_sts one edge later (0 means success, 1 means error). An acknowledge that arrives in software mode also gives a one-cycle pulse on sw_done.
- R6: With auto_mode set, only the first software word is taken. rdy then stays 0, and later sw_cmd_we strobes send nothing.
- R7: After the acknowledge of that first word, every generate pass sends all the words of the generate program, in the order they were written, and leaves the stored program in place.
- R8: A program is not started until the acknowledge for the previous command has arrived. While waiting, cmd_valid stays 0.
- R9: With a reseed limit of N (N at least 1; 0 acts as 1), the reseed program is sent after every N generate programs. The counter reloads from the limit register when the reseed acknowledge arrives.
- R10: While fifo_clear is 1, both program stores are empty and writes to them are dropped. Writes are taken again once fifo_clear returns to 0.
- R11: A write to a program store that already holds 13 words enters the fault state (code 0x1F6) on the next edge. The same happens on a counter copy mismatch or an unlisted state code. In the fault state fatal_err is 1 and cmd_valid and rdy are 0, and only reset leaves it, even if enable is cleared.
- R12: Outside the fault state, clearing enable returns the state code to 0x185 and clears cmd_valid one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable |
| boot_mode | input | 1 | Send the boot pair when leaving idle |
| auto_mode | input | 1 | Automatic replay after the first software word |
| fifo_clear | input | 1 | Empty both program stores and hold them empty |
| wdata | input | 32 | Write data shared by all write strobes |
| sw_cmd_we | input | 1 | Software command word strobe |
| gen_prog_we | input | 1 | Append a word to the generate program |
| res_prog_we | input | 1 | Append a word to the reseed program |
| boot_ins_we | input | 1 | Load the boot instantiate word |
| boot_gen_we | input | 1 | Load the boot generate word |
| reseed_limit_we | input | 1 | Load the generate-requests-per-reseed limit |
| cmd_valid | output | 1 | Command word valid |
| cmd_word | output | 32 | Command word |
| cmd_ready | input | 1 | Generator takes the word |
| cmd_ack | input | 1 | Command completed |
| cmd_ack_err | input | 1 | Completion carried an error |
| rdy | output | 1 | A software word may be written |
| cmd_sts | output | 1 | Status of the latest acknowledge |
| sw_done | output | 1 | Pulse: software command acknowledged |
| fatal_err | output | 1 | Terminal fault |
| state_dbg | output | 9 | Main state code |

## Verification
The bench counts edges for each result. A software or boot word shows on cmd_word one edge after its strobe or state step; the boot instantiate word needs two edges from enable. cmd_sts and sw_done change one edge after an acknowledge. The fault and idle codes appear one edge after the overflowing write or the enable drop. Inputs change on falling edges, and each check is taken on the falling edge that follows the counted rising edges. Multi-word program order is checked against a log of accepted handshakes, compared afterwards with a sequence that the bench works out from the reseed limit.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

  localparam int unsigned STATE_W = 9;

  // Sparse main state codes; reset lands on the idle code.
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE      = 9'h185,
    ST_BINS_TX   = 9'h0E3,
    ST_BINS_WAIT = 9'h1DA,
    ST_BGEN_TX   = 9'h036,
    ST_BGEN_WAIT = 9'h14D,
    ST_BOOT_DONE = 9'h0B8,
    ST_SW        = 9'h12F,
    ST_GEN_TX    = 9'h073,
    ST_GEN_WAIT  = 9'h1C4,
    ST_RES_TX    = 9'h159,
    ST_RES_WAIT  = 9'h0AA,
    ST_FAULT     = 9'h1F6
  } seq_state_e;

endpackage

// File: rtl/cmd_store.sv
// Program store: append-only writes, replay read pointer that wraps after
// the last stored word. Reading never removes a word.
module cmd_store #(
  parameter int W     = 32,
  parameter int DEPTH = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_adv,
  output logic [W-1:0] rd_data,
  output logic         rd_last,
  output logic         empty,
  output logic         ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] rp_q;
  logic          full;
  logic          write_ok;

  assign full     = (cnt_q == CW'(DEPTH));
  assign write_ok = wr_en && !clear && !full;
  assign ovf      = wr_en && !clear && full;
  assign empty    = (cnt_q == '0);
  assign rd_last  = ((CW'(rp_q) + CW'(1)) == cnt_q);
  assign rd_data  = mem[rp_q];

  // No reset on the storage array so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (write_ok) mem[PW'(cnt_q)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      rp_q  <= '0;
    end else begin
      if (write_ok) cnt_q <= cnt_q + CW'(1);
      if (rd_adv && !empty) rp_q <= rd_last ? '0 : rp_q + PW'(1);
    end
  end
endmodule

// File: rtl/req_countdown.sv
// Duplicated down-counter; the copies must agree at all times.
module req_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             le_one,
  output logic             err
);
  logic [CNT_W-1:0] cnt_a_q, cnt_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
    end else if (load) begin
      cnt_a_q <= load_val;
      cnt_b_q <= load_val;
    end else if (dec) begin
      cnt_a_q <= (cnt_a_q == '0) ? '0 : cnt_a_q - CNT_W'(1);
      cnt_b_q <= (cnt_b_q == '0) ? '0 : cnt_b_q - CNT_W'(1);
    end
  end

  assign le_one = (cnt_a_q <= CNT_W'(1));
  assign err    = (cnt_a_q != cnt_b_q);
endmodule

// File: rtl/seq_fsm.sv
// Main sequencing state machine with a one-slot registered output stage.
module seq_fsm
  import rng_seq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         boot_mode,
  input  logic         auto_mode,
  input  logic         sw_we,
  input  logic [W-1:0] sw_word,
  input  logic [W-1:0] boot_ins,
  input  logic [W-1:0] boot_gen,
  input  logic [W-1:0] gen_word,
  input  logic         gen_last,
  input  logic         gen_empty,
  input  logic [W-1:0] res_word,
  input  logic         res_last,
  input  logic         res_empty,
  input  logic         cnt_le_one,
  input  logic         fault_in,
  input  logic         cmd_ready,
  input  logic         cmd_ack,
  input  logic         cmd_ack_err,
  output logic         gen_adv,
  output logic         res_adv,
  output logic         cnt_load,
  output logic         cnt_dec,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_word,
  output logic         rdy,
  output logic         cmd_sts,
  output logic         sw_done,
  output logic         fatal,
  output logic [STATE_W-1:0] state_dbg
);
  seq_state_e   state_q, state_d;
  logic         valid_q, locked_q, sts_q, done_q;
  logic [W-1:0] word_q;
  logic         slot_free, sw_open;
  logic         load, sw_take, flush, bad;
  logic [W-1:0] load_word;

  assign slot_free = !valid_q || cmd_ready;
  assign sw_open   = (state_q == ST_SW) && !valid_q && !locked_q;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    load_word = '0;
    gen_adv   = 1'b0;
    res_adv   = 1'b0;
    cnt_load  = 1'b0;
    cnt_dec   = 1'b0;
    sw_take   = 1'b0;
    flush     = 1'b0;
    bad       = 1'b0;
    case (state_q)
      ST_IDLE: if (enable) state_d = boot_mode ? ST_BINS_TX : ST_SW;
      ST_BINS_TX: if (slot_free) begin
        load = 1'b1; load_word = boot_ins; state_d = ST_BINS_WAIT;
      end
      ST_BINS_WAIT: if (cmd_ack) state_d = ST_BGEN_TX;
      ST_BGEN_TX: if (slot_free) begin
        load = 1'b1; load_word = boot_gen; state_d = ST_BGEN_WAIT;
      end
      ST_BGEN_WAIT: if (cmd_ack) state_d = ST_BOOT_DONE;
      ST_BOOT_DONE: if (!boot_mode) state_d = ST_IDLE;
      ST_SW: begin
        if (sw_we && sw_open) begin
          load = 1'b1; load_word = sw_word; sw_take = 1'b1;
        end
        if (auto_mode && locked_q && cmd_ack) begin
          state_d = ST_GEN_TX; cnt_load = 1'b1;
        end
      end
      ST_GEN_TX: if (!gen_empty && slot_free) begin
        load = 1'b1; load_word = gen_word; gen_adv = 1'b1;
        if (gen_last) state_d = ST_GEN_WAIT;
      end
      ST_GEN_WAIT: if (cmd_ack) begin
        cnt_dec = 1'b1;
        state_d = cnt_le_one ? ST_RES_TX : ST_GEN_TX;
      end
      ST_RES_TX: if (!res_empty && slot_free) begin
        load = 1'b1; load_word = res_word; res_adv = 1'b1;
        if (res_last) state_d = ST_RES_WAIT;
      end
      ST_RES_WAIT: if (cmd_ack) begin
        cnt_load = 1'b1; state_d = ST_GEN_TX;
      end
      ST_FAULT: ;
      default: bad = 1'b1;
    endcase

    if (fault_in || bad) begin
      state_d = ST_FAULT; flush = 1'b1; load = 1'b0; sw_take = 1'b0;
      gen_adv = 1'b0; res_adv = 1'b0; cnt_load = 1'b0; cnt_dec = 1'b0;
    end else if (!enable && state_q != ST_FAULT) begin
      state_d = ST_IDLE; flush = 1'b1; load = 1'b0; sw_take = 1'b0;
      gen_adv = 1'b0; res_adv = 1'b0; cnt_load = 1'b0; cnt_dec = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      valid_q  <= 1'b0;
      word_q   <= '0;
      locked_q <= 1'b0;
      sts_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flush)          valid_q <= 1'b0;
      else if (load)      valid_q <= 1'b1;
      else if (cmd_ready) valid_q <= 1'b0;
      if (load) word_q <= load_word;
      if (state_q == ST_IDLE)         locked_q <= 1'b0;
      else if (sw_take && auto_mode)  locked_q <= 1'b1;
      if (cmd_ack) sts_q <= cmd_ack_err;
      done_q <= cmd_ack && (state_q == ST_SW);
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_word  = word_q;
  assign rdy       = sw_open;
  assign cmd_sts   = sts_q;
  assign sw_done   = done_q;
  assign fatal     = (state_q == ST_FAULT);
  assign state_dbg = state_q;
endmodule

// File: rtl/rng_cmd_sequencer.sv
module rng_cmd_sequencer
  import rng_seq_pkg::*;
#(
  parameter int          W            = 32,
  parameter int          DEPTH        = 13,
  parameter int          CNT_W        = 32,
  parameter logic [31:0] BOOT_INS_RST = 32'h0000_0901,
  parameter logic [31:0] BOOT_GEN_RST = 32'h00FF_F003
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         boot_mode,
  input  logic         auto_mode,
  input  logic         fifo_clear,
  input  logic [W-1:0] wdata,
  input  logic         sw_cmd_we,
  input  logic         gen_prog_we,
  input  logic         res_prog_we,
  input  logic         boot_ins_we,
  input  logic         boot_gen_we,
  input  logic         reseed_limit_we,
  output logic         cmd_valid,
  output logic [W-1:0] cmd_word,
  input  logic         cmd_ready,
  input  logic         cmd_ack,
  input  logic         cmd_ack_err,
  output logic         rdy,
  output logic         cmd_sts,
  output logic         sw_done,
  output logic         fatal_err,
  output logic [8:0]   state_dbg
);
  logic [W-1:0]     boot_ins_q, boot_gen_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_ins_q <= W'(BOOT_INS_RST);
      boot_gen_q <= W'(BOOT_GEN_RST);
      limit_q    <= '0;
    end else begin
      if (boot_ins_we)     boot_ins_q <= wdata;
      if (boot_gen_we)     boot_gen_q <= wdata;
      if (reseed_limit_we) limit_q    <= wdata[CNT_W-1:0];
    end
  end

  logic [W-1:0] gen_word, res_word;
  logic gen_last, gen_empty, gen_ovf, gen_adv;
  logic res_last, res_empty, res_ovf, res_adv;

  cmd_store #(.W(W), .DEPTH(DEPTH)) u_gen_store (
    .clk(clk), .rst(rst), .clear(fifo_clear), .wr_en(gen_prog_we),
    .wr_data(wdata), .rd_adv(gen_adv), .rd_data(gen_word),
    .rd_last(gen_last), .empty(gen_empty), .ovf(gen_ovf)
  );

  cmd_store #(.W(W), .DEPTH(DEPTH)) u_res_store (
    .clk(clk), .rst(rst), .clear(fifo_clear), .wr_en(res_prog_we),
    .wr_data(wdata), .rd_adv(res_adv), .rd_data(res_word),
    .rd_last(res_last), .empty(res_empty), .ovf(res_ovf)
  );

  logic cnt_load, cnt_dec, cnt_le_one, cnt_err;

  req_countdown #(.CNT_W(CNT_W)) u_countdown (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(limit_q),
    .dec(cnt_dec), .le_one(cnt_le_one), .err(cnt_err)
  );

  logic fault_now;
  assign fault_now = gen_ovf || res_ovf || cnt_err;

  seq_fsm #(.W(W)) u_fsm (
    .clk(clk), .rst(rst), .enable(enable), .boot_mode(boot_mode),
    .auto_mode(auto_mode), .sw_we(sw_cmd_we), .sw_word(wdata),
    .boot_ins(boot_ins_q), .boot_gen(boot_gen_q),
    .gen_word(gen_word), .gen_last(gen_last), .gen_empty(gen_empty),
    .res_word(res_word), .res_last(res_last), .res_empty(res_empty),
    .cnt_le_one(cnt_le_one), .fault_in(fault_now),
    .cmd_ready(cmd_ready), .cmd_ack(cmd_ack), .cmd_ack_err(cmd_ack_err),
    .gen_adv(gen_adv), .res_adv(res_adv), .cnt_load(cnt_load),
    .cnt_dec(cnt_dec), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rdy(rdy), .cmd_sts(cmd_sts), .sw_done(sw_done), .fatal(fatal_err),
    .state_dbg(state_dbg)
  );
endmodule

// File: rtl/rng_cmd_sequencer_chk.sv
module rng_cmd_sequencer_chk
  import rng_seq_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         enable,
  input logic         cmd_valid,
  input logic [W-1:0] cmd_word,
  input logic         cmd_ready,
  input logic         cmd_ack,
  input logic         cmd_ack_err,
  input logic         rdy,
  input logic         cmd_sts,
  input logic         sw_done,
  input logic         fatal_err,
  input logic [8:0]   state_dbg,
  input logic         fault_now
);
  p_rdy_empty_r3: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !cmd_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready && enable && !fault_now)
      |=> (cmd_valid && $stable(cmd_word)));

  p_sts_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |=> (cmd_sts == $past(cmd_ack_err)));

  p_done_r5: assert property (@(posedge clk) disable iff (rst)
    sw_done |-> $past(cmd_ack));

  p_fault_entry_r11: assert property (@(posedge clk) disable iff (rst)
    fault_now |=> fatal_err);

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    fatal_err |=> (fatal_err && state_dbg == ST_FAULT));

  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    fatal_err |-> (!cmd_valid && !rdy));

  p_disable_r12: assert property (@(posedge clk) disable iff (rst)
    (!enable && !fatal_err && !fault_now)
      |=> (state_dbg == ST_IDLE && !cmd_valid));
endmodule

bind rng_cmd_sequencer rng_cmd_sequencer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .cmd_valid(cmd_valid),
  .cmd_word(cmd_word), .cmd_ready(cmd_ready), .cmd_ack(cmd_ack),
  .cmd_ack_err(cmd_ack_err), .rdy(rdy), .cmd_sts(cmd_sts),
  .sw_done(sw_done), .fatal_err(fatal_err), .state_dbg(state_dbg),
  .fault_now(fault_now)
);

// File: tb/sim_rng_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_rng_cmd_sequencer;
  logic clk = 1'b0;
  logic rst, enable, boot_mode, auto_mode, fifo_clear;
  logic [31:0] wdata;
  logic sw_cmd_we, gen_prog_we, res_prog_we, boot_ins_we, boot_gen_we, reseed_limit_we;
  logic cmd_valid, cmd_ready, cmd_ack, cmd_ack_err;
  logic [31:0] cmd_word;
  logic rdy, cmd_sts, sw_done, fatal_err;
  logic [8:0] state_dbg;

  always #2.5 clk = ~clk;

  rng_cmd_sequencer u0 (
    .clk(clk), .rst(rst), .enable(enable), .boot_mode(boot_mode),
    .auto_mode(auto_mode), .fifo_clear(fifo_clear), .wdata(wdata),
    .sw_cmd_we(sw_cmd_we), .gen_prog_we(gen_prog_we), .res_prog_we(res_prog_we),
    .boot_ins_we(boot_ins_we), .boot_gen_we(boot_gen_we),
    .reseed_limit_we(reseed_limit_we), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .cmd_ready(cmd_ready), .cmd_ack(cmd_ack),
    .cmd_ack_err(cmd_ack_err), .rdy(rdy), .cmd_sts(cmd_sts),
    .sw_done(sw_done), .fatal_err(fatal_err), .state_dbg(state_dbg)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Log of every accepted handshake.
  logic [31:0] cap [64];
  int cap_n = 0;
  always @(posedge clk) begin
    if (!rst && cmd_valid && cmd_ready && cap_n < 64) begin
      cap[cap_n] <= cmd_word;
      cap_n <= cap_n + 1;
    end
  end

  // {word, ack error, cycles of back-pressure}
  localparam logic [36:0] VEC [5] = '{
    {32'h0000_0001, 1'b0, 4'd0},
    {32'hA5A5_0F0F, 1'b1, 4'd2},
    {32'h1234_5678, 1'b0, 4'd1},
    {32'hFFFF_FFFF, 1'b1, 4'd0},
    {32'h0000_0000, 1'b0, 4'd3}
  };

  localparam logic [31:0] G0 = 32'h0000_1003, G1 = 32'h1111_2222;
  localparam logic [31:0] S0 = 32'h0000_2002, S1 = 32'h3333_4444, S2 = 32'h5555_6666;
  localparam logic [31:0] INST = 32'h0000_0101;
  localparam int LIMIT = 2;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic pulse_ack(input logic e);
    cmd_ack = 1'b1; cmd_ack_err = e;
    tick(1);
    cmd_ack = 1'b0; cmd_ack_err = 1'b0;
  endtask

  task automatic wait_words(input int target, input string req);
    int n = 0;
    while (cap_n < target && n < 100) begin
      tick(1);
      n++;
    end
    check(cap_n >= target, req, "word count reached", cap_n, target);
  endtask

  task automatic write_prog(input bit to_gen, input logic [31:0] w);
    wdata = w;
    if (to_gen) gen_prog_we = 1'b1; else res_prog_we = 1'b1;
    tick(1);
    gen_prog_we = 1'b0; res_prog_we = 1'b0;
  endtask

  initial begin
    rst = 1'b1; enable = 0; boot_mode = 0; auto_mode = 0; fifo_clear = 0;
    wdata = '0; sw_cmd_we = 0; gen_prog_we = 0; res_prog_we = 0;
    boot_ins_we = 0; boot_gen_we = 0; reseed_limit_we = 0;
    cmd_ready = 1'b1; cmd_ack = 0; cmd_ack_err = 0;
    tick(3);
    rst = 1'b0;

    // R1 reset state
    check(state_dbg == 9'h185, "R1", "reset state code", 32'(state_dbg), 32'h185);
    check(!cmd_valid && !rdy && !cmd_sts && !sw_done && !fatal_err, "R1",
          "reset outputs", {27'd0, cmd_valid, rdy, cmd_sts, sw_done, fatal_err}, 32'd0);

    // R2 boot pair
    enable = 1'b1; boot_mode = 1'b1;
    tick(2);
    check(cmd_valid && cmd_word == 32'h0000_0901, "R1", "boot instantiate word", cmd_word, 32'h0000_0901);
    tick(4);
    check(!cmd_valid && cap_n == 1, "R2", "nothing before boot ack", cap_n, 1);
    pulse_ack(1'b0);
    tick(1);
    check(cmd_valid && cmd_word == 32'h00FF_F003, "R2", "boot generate word", cmd_word, 32'h00FF_F003);
    tick(1);
    pulse_ack(1'b0);
    tick(4);
    check(!cmd_valid && cap_n == 2, "R2", "quiet after boot pair", cap_n, 2);
    boot_mode = 1'b0;
    tick(2);
    check(rdy == 1'b1 && state_dbg == 9'h12F, "R2", "software mode after boot", 32'(state_dbg), 32'h12F);

    // Software forwarding table
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w;
      logic e;
      int hold;
      w = VEC[i][36:5]; e = VEC[i][4]; hold = int'(VEC[i][3:0]);
      cmd_ready = (hold == 0);
      wdata = w; sw_cmd_we = 1'b1;
      tick(1);
      sw_cmd_we = 1'b0;
      check(cmd_valid && cmd_word == w, "R3", "forwarded word", cmd_word, w);
      check(!rdy, "R3", "rdy low while held", 32'(rdy), 32'd0);
      if (hold > 0) begin
        tick(hold);
        check(cmd_valid && cmd_word == w, "R4", "held under back-pressure", cmd_word, w);
        cmd_ready = 1'b1;
      end
      tick(1);
      check(!cmd_valid && rdy, "R3", "slot free after handshake", 32'(rdy), 32'd1);
      pulse_ack(e);
      check(cmd_sts == e && sw_done, "R5", "status and done pulse", {30'd0, cmd_sts, sw_done}, {30'd0, e, 1'b1});
      tick(1);
      check(!sw_done, "R5", "done is one cycle", 32'(sw_done), 32'd0);
    end

    // Automatic mode
    wdata = 32'(LIMIT); reseed_limit_we = 1'b1; tick(1); reseed_limit_we = 1'b0;
    write_prog(1'b1, G0); write_prog(1'b1, G1);
    write_prog(1'b0, S0); write_prog(1'b0, S1); write_prog(1'b0, S2);
    auto_mode = 1'b1;
    begin
      int base;
      logic [31:0] exp [16];
      bit is_res [16];
      int k;
      int cnt;
      int lens [6];
      int total;
      base = cap_n;
      exp[0] = INST; is_res[0] = 0; k = 1; cnt = LIMIT;
      for (int p = 0; p < 6; p++) begin
        if (p > 0 && lens[p-1] == 3) ;
        lens[p] = 0;
      end
      // Program order from the limit: generate, then reseed whenever the count is spent.
      begin
        bit nxt_res = 0;
        for (int p = 0; p < 6; p++) begin
          if (!nxt_res) begin
            exp[k] = G0; exp[k+1] = G1; is_res[k] = 0; is_res[k+1] = 0;
            k += 2; lens[p] = 2;
            if (cnt <= 1) nxt_res = 1; else cnt--;
          end else begin
            exp[k] = S0; exp[k+1] = S1; exp[k+2] = S2;
            is_res[k] = 1; is_res[k+1] = 1; is_res[k+2] = 1;
            k += 3; lens[p] = 3; nxt_res = 0; cnt = LIMIT;
          end
        end
      end
      wdata = INST; sw_cmd_we = 1'b1; tick(1); sw_cmd_we = 1'b0;
      wait_words(base + 1, "R6");
      check(!rdy, "R6", "rdy stays low in auto mode", 32'(rdy), 32'd0);
      wdata = 32'hDEAD_BEEF; sw_cmd_we = 1'b1; tick(1); sw_cmd_we = 1'b0;
      tick(1);
      pulse_ack(1'b0);
      total = base + 1;
      for (int p = 0; p < 6; p++) begin
        total += lens[p];
        wait_words(total, "R7");
        if (p == 0) begin
          tick(4);
          check(cap_n == total && !cmd_valid, "R8", "no new program before ack", cap_n, total);
        end
        tick(1);
        pulse_ack(1'b0);
      end
      for (int i = 0; i < k; i++) begin
        if (is_res[i])
          check(cap[base+i] == exp[i], "R9", "reseed placement", cap[base+i], exp[i]);
        else
          check(cap[base+i] == exp[i], "R7", "replayed word", cap[base+i], exp[i]);
      end
      begin
        int dead = 0;
        for (int i = 0; i < cap_n; i++) if (cap[i] == 32'hDEAD_BEEF) dead++;
        check(dead == 0, "R6", "ignored software write", dead, 0);
      end
    end

    // R12 disable mid-sequence
    enable = 1'b0; auto_mode = 1'b0;
    tick(1);
    check(state_dbg == 9'h185 && !cmd_valid, "R12", "idle after disable", 32'(state_dbg), 32'h185);

    // R10 clear
    fifo_clear = 1'b1; tick(1);
    write_prog(1'b1, 32'h7777_0000);
    fifo_clear = 1'b0;
    enable = 1'b1; auto_mode = 1'b1; tick(1);
    begin
      int base2;
      base2 = cap_n;
      wdata = 32'h0000_0201; sw_cmd_we = 1'b1; tick(1); sw_cmd_we = 1'b0;
      wait_words(base2 + 1, "R10");
      tick(1);
      pulse_ack(1'b0);
      tick(6);
      check(cap_n == base2 + 1 && !cmd_valid, "R10", "stores empty after clear", cap_n, base2 + 1);
      write_prog(1'b1, 32'h0000_0A0A);
      wait_words(base2 + 2, "R10");
      check(cap[base2+1] == 32'h0000_0A0A, "R10", "write taken after clear", cap[base2+1], 32'h0000_0A0A);
    end

    // R11 overflow
    for (int i = 0; i < 13; i++) write_prog(1'b0, 32'h0000_C000 + 32'(i));
    check(!fatal_err, "R11", "13 words fit", 32'(fatal_err), 32'd0);
    write_prog(1'b0, 32'h0000_CCCC);
    check(fatal_err && state_dbg == 9'h1F6 && !cmd_valid, "R11", "fault on 14th word",
          32'(state_dbg), 32'h1F6);
    enable = 1'b0;
    tick(3);
    check(fatal_err && state_dbg == 9'h1F6, "R11", "fault is terminal", 32'(state_dbg), 32'h1F6);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule